// File: doc/BRIEF.md
# Lockable Peripheral Clock-Gating Controller

This block is a register-mapped controller that stops or runs the clocks of seven peripheral cores and holds any of them in reset. Software reaches it through a small APB-style slave port. Three word registers are exposed: a lock-release (unlock) mask, a clock-run mask and a core-reset mask. Each bit of the clock-run and core-reset masks is protected by the unlock bit in the same position. Software must first set that unlock bit, then change the protected bit, then clear the unlock bit again. The hardware enforces this sequence bit by bit, so a stray write cannot stop or reset a core that was not released first.

Seven bits are implemented. Bits 0 to 3 serve four serial link cores, bit 4 serves a pair of bus-controller cores that share one clock, bit 5 serves an Ethernet MAC and bit 6 serves a PCI bridge. The clock-enable and reset outputs come straight from flops on the bus clock. A latch-based clock-gate cell placed downstream therefore never sees a combinational glitch on its enable.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset the unlock mask reads 0x00, the clock-run mask reads 0x7F with every `core_clk_en` bit high, and the core-reset mask reads 0x00 with every `core_rst` bit low.
- R2: The unlock mask at offset 0x0 accepts every write in bits 6:0, whatever the other masks hold. Bits 31:7 of written data are dropped, and bits 31:7 of every read return zero.
- R3: A write to the clock-run mask at offset 0x4 updates only the bits whose unlock bit is 1 at the time of the write. Every other bit keeps its previous value.
- R4: A write to the core-reset mask at offset 0x8 follows the same per-bit unlock rule as R3.
- R5: `core_clk_en[i]` equals bit i of the clock-run mask, where 1 runs the clock and 0 stops it. It changes only at the rising edge that ends a write access to offset 0x4.
- R6: `core_rst[i]` stays high for as long as bit i of the core-reset mask holds 1.
- R7: A read during an access returns the addressed mask in bits 6:0. Any offset other than 0x0, 0x4 or 0x8 (misaligned ones included) reads as zero.
- R8: A register changes only at the rising edge where `psel`, `penable` and `pwrite` are all high. A setup phase alone or a read access leaves every register unchanged.
- R9: `pready` is always 1, so every access completes without wait states.
- R10: A write to any offset other than 0x0, 0x4 or 0x8 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every register is clocked on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W (4) | Byte offset of the register |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while `psel` is high |
| pready | output | 1 | Always 1 |
| core_clk_en | output | NUM_CORES (7) | Registered clock-run enables, one per core |
| core_rst | output | NUM_CORES (7) | Registered core resets, active high |

## Verification
Both masks drive their output pins directly, so a bit that escapes its lock shows up on `core_clk_en` or `core_rst` at the first compare after the faulty edge. The bench checks those pins against a behavioural model after every rising clock edge. The unlock mask reaches no pin directly. A wrong unlock bit therefore shows up only when a later protected write lands where it should not, or fails to land where it should. Readback of offset 0x0 exposes it within one access. Decode errors (a wrong offset, an ignored misaligned address, a missed setup-phase qualifier) show up as a mask changing during a directed access that was meant to have no effect.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  // Read-source selector produced by the address decoder
  typedef enum logic [1:0] {
    RSEL_UNLOCK = 2'd0,
    RSEL_ENABLE = 2'd1,
    RSEL_RESET  = 2'd2,
    RSEL_NONE   = 2'd3
  } rsel_e;

  // Word indices of the three masks; the order is the software-visible map
  localparam int unsigned WIDX_UNLOCK = 0;
  localparam int unsigned WIDX_ENABLE = 1;
  localparam int unsigned WIDX_RESET  = 2;

  // True when a byte offset is word aligned and names the given word index
  function automatic logic offset_hits(input logic [31:0] offs, input int unsigned widx);
    return (offs[1:0] == 2'b00) && (offs[31:2] == 30'(widx));
  endfunction

  // Per-bit guarded update: allowed bits take the new value, others hold
  function automatic logic guarded_bit(input logic old_b, input logic new_b, input logic allow);
    return allow ? new_b : old_b;
  endfunction

endpackage

// File: rtl/clkgate_decode.sv
module clkgate_decode
  import clkgate_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              wr_unlock,
  output logic              wr_enable,
  output logic              wr_reset,
  output rsel_e             rsel
);

  logic [31:0] offs;
  logic        hit_unlock;
  logic        hit_enable;
  logic        hit_reset;
  logic        wr_access;

  assign offs       = 32'(paddr);
  assign hit_unlock = offset_hits(offs, WIDX_UNLOCK);
  assign hit_enable = offset_hits(offs, WIDX_ENABLE);
  assign hit_reset  = offset_hits(offs, WIDX_RESET);

  // The write commits on the edge that closes the access phase
  assign wr_access = psel && penable && pwrite;

  assign wr_unlock = wr_access && hit_unlock;
  assign wr_enable = wr_access && hit_enable;
  assign wr_reset  = wr_access && hit_reset;

  always_comb begin
    if (hit_unlock)      rsel = RSEL_UNLOCK;
    else if (hit_enable) rsel = RSEL_ENABLE;
    else if (hit_reset)  rsel = RSEL_RESET;
    else                 rsel = RSEL_NONE;
  end

endmodule

// File: rtl/clkgate_lockreg.sv
module clkgate_lockreg
  import clkgate_pkg::*;
#(
  parameter int unsigned         W       = 7,
  parameter logic [W-1:0]        RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] unlock,
  output logic [W-1:0] q
);

  // One flop per bit, each guarded by its own unlock bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= RST_VAL[i];
      else if (we) bit_q <= guarded_bit(bit_q, wdata[i], unlock[i]);
    end
    assign q[i] = bit_q;
  end

  // R3 R4: bits whose unlock was clear at the edge never move
  locked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & ~$past(unlock)) == '0);

  // R5 R8: without a write strobe the mask is frozen
  mask_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int unsigned NUM_CORES = 7,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic                 pready,
  output logic [NUM_CORES-1:0] core_clk_en,
  output logic [NUM_CORES-1:0] core_rst
);

  localparam logic [NUM_CORES-1:0] EN_RST_VAL  = {NUM_CORES{1'b1}};
  localparam logic [NUM_CORES-1:0] RST_RST_VAL = '0;

  logic                 wr_unlock;
  logic                 wr_enable;
  logic                 wr_reset;
  rsel_e                rsel;
  logic [NUM_CORES-1:0] unlock_q;
  logic [NUM_CORES-1:0] enable_q;
  logic [NUM_CORES-1:0] reset_q;
  logic [NUM_CORES-1:0] wdata_lo;

  assign wdata_lo = pwdata[NUM_CORES-1:0];

  clkgate_decode #(.ADDR_W(ADDR_W)) u_decode (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .wr_unlock (wr_unlock),
    .wr_enable (wr_enable),
    .wr_reset  (wr_reset),
    .rsel      (rsel)
  );

  // Unlock mask: always writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlock_q <= '0;
    else if (wr_unlock) unlock_q <= wdata_lo;
  end

  clkgate_lockreg #(.W(NUM_CORES), .RST_VAL(EN_RST_VAL)) u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_enable),
    .wdata  (wdata_lo),
    .unlock (unlock_q),
    .q      (enable_q)
  );

  clkgate_lockreg #(.W(NUM_CORES), .RST_VAL(RST_RST_VAL)) u_reset (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_reset),
    .wdata  (wdata_lo),
    .unlock (unlock_q),
    .q      (reset_q)
  );

  // Outputs come straight from flops: no glitch reaches the gate cells
  assign core_clk_en = enable_q;
  assign core_rst    = reset_q;
  assign pready      = 1'b1;

  always_comb begin
    prdata = '0;
    if (psel) begin
      unique case (rsel)
        RSEL_UNLOCK: prdata[NUM_CORES-1:0] = unlock_q;
        RSEL_ENABLE: prdata[NUM_CORES-1:0] = enable_q;
        RSEL_RESET:  prdata[NUM_CORES-1:0] = reset_q;
        default:     prdata = '0;
      endcase
    end
  end

  // R7
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && rsel == RSEL_NONE) |-> prdata == '0);

  // R2
  upper_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> prdata[DATA_W-1:NUM_CORES] == '0);

  // R2
  unlock_takes_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unlock && pwdata[DATA_W-1:NUM_CORES] != '0) |=> unlock_q == $past(wdata_lo));

  // R8 R10
  unlock_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_unlock |=> $stable(unlock_q));

  // R6
  reset_pin_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_reset) == 1'b0 |-> $stable(core_rst));

endmodule

// File: tb/clkgate_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [6:0]  core_clk_en;
  logic [6:0]  core_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  clkgate_ctrl u_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .core_clk_en(core_clk_en), .core_rst(core_rst)
  );

  // Behavioural reference model of the three masks
  int ref_unlock, ref_en, ref_rst;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_unlock <= 0; ref_en <= 'h7F; ref_rst <= 0;
    end else if (psel && penable && pwrite) begin
      if (paddr == 4'h0) ref_unlock <= int'(pwdata) & 'h7F;
      else if (paddr == 4'h4)
        ref_en <= (ref_en & ~ref_unlock) | (int'(pwdata) & ref_unlock & 'h7F);
      else if (paddr == 4'h8)
        ref_rst <= (ref_rst & ~ref_unlock) | (int'(pwdata) & ref_unlock & 'h7F);
    end
  end

  function automatic int ref_read(input logic [3:0] a);
    case (a)
      4'h0: return ref_unlock;
      4'h4: return ref_en;
      4'h8: return ref_rst;
      default: return 0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison of the pins against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(32'(core_clk_en), ref_en, "R5 clock enables");
      check(32'(core_rst), ref_rst, "R6 core resets");
      check(32'(pready), 1, "R9 ready");
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 check(prdata, exp, tag);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check(32'(core_clk_en), 'h7F, "R1 enables after reset");
    check(32'(core_rst), 0, "R1 resets after reset");
    bus_read(4'h0, 0, "R1 unlock reset value");
    bus_read(4'h4, 'h7F, "R1 enable reset value");
    bus_read(4'h8, 0, "R1 reset mask reset value");
    // R3 locked write ignored
    bus_write(4'h4, 0);
    bus_read(4'h4, 'h7F, "R3 locked enable write");
    // R2 unlock writable, upper bits dropped
    bus_write(4'h0, 32'hFFFF_FFA0);
    bus_read(4'h0, 'h20, "R2 unlock readback");
    // R3 only unlocked bit moves
    bus_write(4'h4, 0);
    bus_read(4'h4, 'h5F, "R3 single-bit enable change");
    check(32'(core_clk_en), 'h5F, "R5 stopped clock pin");
    // R4 R6
    bus_write(4'h8, 32'hFF);
    bus_read(4'h8, 'h20, "R4 single-bit reset set");
    check(32'(core_rst), 'h20, "R6 reset pin held");
    bus_write(4'h8, 0);
    bus_read(4'h8, 0, "R4 reset release");
    // relock then try to restart
    bus_write(4'h0, 0);
    bus_write(4'h4, 'h7F);
    bus_read(4'h4, 'h5F, "R3 relocked write ignored");
    // R8 setup phase alone
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 4'h0; pwdata = 'h7F;
    @(negedge clk); psel = 0; pwrite = 0;
    bus_read(4'h0, 0, "R8 setup-only write ignored");
    // R10 unmapped and misaligned writes
    bus_write(4'hC, 'h7F);
    bus_write(4'h1, 'h7F);
    bus_read(4'h0, 0, "R10 unmapped write ignored");
    // R7 unmapped reads
    bus_read(4'hC, 0, "R7 unmapped read");
    bus_read(4'h5, 0, "R7 misaligned read");
    // Full unlock and patterns
    bus_write(4'h0, 'h7F);
    bus_write(4'h4, 'h2A);
    bus_write(4'h8, 'h55);
    bus_read(4'h4, 'h2A, "R3 pattern");
    bus_read(4'h8, 'h55, "R4 pattern");
    // Random traffic against the model
    for (int n = 0; n < 300; n++) begin
      logic [3:0] a;
      a = 4'({$urandom_range(0, 3), 2'b00});
      if ($urandom_range(0, 1) == 1) bus_write(a, $urandom);
      else bus_read(a, ref_read(a), "R7 random read");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule